// File: doc/BRIEF.md
# Edge/Level Interrupt Pin Servicer

This block sits between a bank of interrupt input pins and the stage that picks a destination processor. For each pin it reads the matching redirection entry (vector, mask, trigger mode, polarity) from the register file. It turns the raw pin into an effective level and keeps a pending bit for each pin. For level-triggered pins it also keeps a remote-IRR bit. From these it decides when a pin is serviced, and each service that is not masked becomes a delivery request carrying the pin number, its vector and its trigger mode.

End-of-interrupt messages arrive as a vector. Each one is matched to the lowest-numbered entry that holds that vector, which releases that pin's remote-IRR bit and can cause a delivery to be issued again. The register file can also pulse a per-pin re-evaluate input after rewriting an entry, so that a pending request is serviced with the new settings. Services are granted one per cycle, lowest pin first. Requests leave through a single registered ready/valid slot.

Top module: `irq_pin_servicer`

## Requirements
- R1: A pin's effective level is its raw input XOR the entry's polarity bit (polarity 1 = active low). Only a 0-to-1 change of the effective level counts as an assertion.
- R2: While a pin's effective level is low its pending bit is cleared. A level-triggered pin whose level drops before it is serviced is not delivered.
- R3: An edge-triggered pin (trigger bit 0) produces exactly one delivery for each rise of its effective level. Holding the level high produces no further deliveries.
- R4: A level-triggered pin (trigger bit 1) sets its remote-IRR bit in the cycle its service loads the output slot. Further rises of the level while remote-IRR is set produce no delivery.
- R5: Servicing a pin whose mask bit is 1 issues no request. For an edge pin, that service still clears the pending bit. A level pin stays pending.
- R6: An EOI clears remote-IRR only on the lowest-numbered entry whose vector equals the EOI vector. Other entries with the same vector keep their remote-IRR.
- R7: An EOI whose vector matches no entry changes no remote-IRR bit and issues no delivery.
- R8: On a matching EOI, if the entry is unmasked and its pending bit is still set, one delivery is issued again, and this delivery does not set remote-IRR. If the level is low, no delivery follows.
- R9: A re-evaluate pulse on a pin whose pending bit is set services that pin.
- R10: At most one pin is granted per cycle, and the lowest-numbered waiting pin goes first.
- R11: While req_valid is 1 and req_ready is 0, req_pin, req_vector and req_level hold their values, and no request is lost.
- R12: During reset req_valid is 0 and every remote-IRR bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | NUM_PINS | Raw interrupt inputs |
| ent_vector | input | NUM_PINS*VEC_W | Vector field of each entry, pin i at bits [i*VEC_W +: VEC_W] |
| ent_mask | input | NUM_PINS | Mask bit of each entry (1 = masked) |
| ent_level | input | NUM_PINS | Trigger mode of each entry (1 = level, 0 = edge) |
| ent_polarity | input | NUM_PINS | Polarity of each entry (1 = active low) |
| reeval | input | NUM_PINS | One-cycle re-evaluate pulse for each pin |
| eoi_valid | input | 1 | EOI message present this cycle |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| remote_irr | output | NUM_PINS | Remote-IRR bit of each pin, returned to the register file |
| req_valid | output | 1 | Delivery request present |
| req_ready | input | 1 | Destination stage accepts the request |
| req_pin | output | $clog2(NUM_PINS) | Pin being delivered |
| req_vector | output | VEC_W | Vector of the delivered pin |
| req_level | output | 1 | Trigger mode of the delivered pin |

## Verification
The hardest situation to reach from the ports is a redelivery after an EOI: a level pin must be delivered, stay asserted, and then receive an EOI for its vector, and the resulting delivery must leave remote-IRR clear. The bench reaches it by raising a level pin and letting its first delivery drain. It then sends the EOI while the pin is still high and counts the extra handshake. A second hard case is two entries sharing a vector. Both are driven to set remote-IRR, their inputs are dropped, and one EOI must release only the lower pin. Priority and holding are exercised by stalling req_ready while two edge pins rise in the same cycle.

// File: rtl/irqsvc_pkg.sv
package irqsvc_pkg;
   typedef enum logic [1:0] {
      PICK_NONE    = 2'd0,
      PICK_SERVICE = 2'd1,
      PICK_REDO    = 2'd2
   } pick_kind_e;
endpackage

// File: rtl/irqsvc_prio_pick.sv
module irqsvc_prio_pick #(
   parameter int W  = 8,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx,
   output logic [W-1:0]  grant
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      grant = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) begin
            found    = 1'b1;
            idx      = IW'(i);
            grant    = '0;
            grant[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irqsvc_pin_lane.sv
module irqsvc_pin_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic polarity,
   input  logic level_mode,
   input  logic masked,
   input  logic reeval,
   input  logic eoi_hit,
   input  logic pick_svc,
   input  logic pick_redo,
   output logic want_svc,
   output logic want_redo,
   output logic rirr
);
   logic eff, eff_q, pend, rise, fire, drop_level;

   assign eff        = raw ^ polarity;
   assign rise       = eff & ~eff_q;
   assign fire       = rise & ((~level_mode & ~pend) | ~rirr);
   assign drop_level = ~eff & level_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eff_q     <= 1'b0;
         pend      <= 1'b0;
         rirr      <= 1'b0;
         want_svc  <= 1'b0;
         want_redo <= 1'b0;
      end else begin
         eff_q <= eff;
         // grant effects come first, later events override them
         if (pick_svc) begin
            want_svc <= 1'b0;
            if (!level_mode) pend <= 1'b0;
         end
         if (pick_redo) want_redo <= 1'b0;
         if (eoi_hit) begin
            rirr <= 1'b0;
            if (!masked && pend) want_redo <= 1'b1;
         end
         // a delivery in flight keeps remote-IRR set over a same-cycle EOI
         if (pick_svc && level_mode && !masked) rirr <= 1'b1;
         if (!eff) begin
            pend <= 1'b0;
            if (level_mode) begin
               want_svc  <= 1'b0;
               want_redo <= 1'b0;
            end
         end else if (rise) begin
            pend <= 1'b1;
         end
         if (fire || (reeval && pend && !drop_level)) want_svc <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_pin_servicer.sv
module irq_pin_servicer #(
   parameter int NUM_PINS = 8,
   parameter int VEC_W    = 8,
   parameter int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PINS-1:0]       pin_raw,
   input  logic [NUM_PINS*VEC_W-1:0] ent_vector,
   input  logic [NUM_PINS-1:0]       ent_mask,
   input  logic [NUM_PINS-1:0]       ent_level,
   input  logic [NUM_PINS-1:0]       ent_polarity,
   input  logic [NUM_PINS-1:0]       reeval,
   input  logic                      eoi_valid,
   input  logic [VEC_W-1:0]          eoi_vector,
   output logic [NUM_PINS-1:0]       remote_irr,
   output logic                      req_valid,
   input  logic                      req_ready,
   output logic [IDX_W-1:0]          req_pin,
   output logic [VEC_W-1:0]          req_vector,
   output logic                      req_level
);
   import irqsvc_pkg::*;

   if (NUM_PINS < 1 || NUM_PINS > 256) begin : g_bad_pins
      $error("NUM_PINS out of range");
   end
   if (VEC_W < 1) begin : g_bad_vec
      $error("VEC_W must be positive");
   end

   logic [NUM_PINS-1:0] want_svc, want_redo, eoi_match, eoi_hit;
   logic [NUM_PINS-1:0] pick_svc, pick_redo, grant;
   logic [IDX_W-1:0]    pick_idx, eoi_idx;
   logic                pick_found, eoi_found, slot_free, pick_en, deliver;
   pick_kind_e          kind;

   // EOI lookup: lowest entry holding the vector
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_match
      assign eoi_match[i] = eoi_valid && (ent_vector[i*VEC_W +: VEC_W] == eoi_vector);
   end

   irqsvc_prio_pick #(.W(NUM_PINS), .IW(IDX_W)) u_eoi_pick (
      .req(eoi_match), .found(eoi_found), .idx(eoi_idx), .grant(eoi_hit)
   );

   // service arbitration
   irqsvc_prio_pick #(.W(NUM_PINS), .IW(IDX_W)) u_svc_pick (
      .req(want_svc | want_redo), .found(pick_found), .idx(pick_idx), .grant(grant)
   );

   assign slot_free = !req_valid || req_ready;
   assign pick_en   = slot_free && pick_found;

   always_comb begin
      if (!pick_en)                kind = PICK_NONE;
      else if (want_svc[pick_idx]) kind = PICK_SERVICE;
      else                         kind = PICK_REDO;
   end

   assign pick_svc  = (kind == PICK_SERVICE) ? grant : '0;
   assign pick_redo = (kind == PICK_REDO)    ? grant : '0;
   assign deliver   = (kind != PICK_NONE) && !ent_mask[pick_idx];

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
      irqsvc_pin_lane u_lane (
         .clk(clk), .rst_n(rst_n),
         .raw(pin_raw[i]), .polarity(ent_polarity[i]),
         .level_mode(ent_level[i]), .masked(ent_mask[i]),
         .reeval(reeval[i]), .eoi_hit(eoi_hit[i]),
         .pick_svc(pick_svc[i]), .pick_redo(pick_redo[i]),
         .want_svc(want_svc[i]), .want_redo(want_redo[i]),
         .rirr(remote_irr[i])
      );
   end

   // output slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid  <= 1'b0;
         req_pin    <= '0;
         req_vector <= '0;
         req_level  <= 1'b0;
      end else if (slot_free) begin
         req_valid <= deliver;
         if (deliver) begin
            req_pin    <= pick_idx;
            req_vector <= ent_vector[pick_idx*VEC_W +: VEC_W];
            req_level  <= ent_level[pick_idx];
         end
      end
   end
endmodule

// File: rtl/irqsvc_checker.sv
module irqsvc_checker #(
   parameter int NUM_PINS = 8,
   parameter int VEC_W    = 8,
   parameter int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_PINS*VEC_W-1:0] ent_vector,
   input logic                      eoi_valid,
   input logic [VEC_W-1:0]          eoi_vector,
   input logic [NUM_PINS-1:0]       remote_irr,
   input logic                      req_valid,
   input logic                      req_ready,
   input logic [IDX_W-1:0]          req_pin,
   input logic [VEC_W-1:0]          req_vector,
   input logic                      req_level
);
   logic any_match;
   always_comb begin
      any_match = 1'b0;
      for (int i = 0; i < NUM_PINS; i++)
         if (ent_vector[i*VEC_W +: VEC_W] == eoi_vector) any_match = 1'b1;
   end

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_pin)
                                     && $stable(req_vector) && $stable(req_level)));

   assert_nomatch_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && !any_match) |=> (($past(remote_irr) & ~remote_irr) == '0));

   assert_reset_idle_R12: assert property (@(posedge clk)
      !rst_n |=> (!req_valid && remote_irr == '0));

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      assert_rirr_with_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(remote_irr[i]) |-> (req_valid && req_pin == IDX_W'(i) && req_level));
   end
endmodule

bind irq_pin_servicer irqsvc_checker #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ent_vector(ent_vector), .eoi_valid(eoi_valid),
   .eoi_vector(eoi_vector), .remote_irr(remote_irr), .req_valid(req_valid),
   .req_ready(req_ready), .req_pin(req_pin), .req_vector(req_vector), .req_level(req_level)
);

// File: tb/tb_irq_pin_servicer.sv
module tb_irq_pin_servicer;
   localparam int N = 8;
   localparam int V = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] pin_raw = '0, ent_mask = '1, ent_level = '0, ent_polarity = '0, reeval = '0;
   logic [N*V-1:0] ent_vector;
   logic eoi_valid = 1'b0;
   logic [V-1:0] eoi_vector = '0;
   logic [N-1:0] remote_irr;
   logic req_valid, req_ready = 1'b1, req_level;
   logic [IW-1:0] req_pin;
   logic [V-1:0] req_vector;

   int checks = 0, errors = 0, n_log = 0;
   int log_pin[64];
   int log_vec[64];
   int log_lvl[64];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_pin_servicer #(.NUM_PINS(N), .VEC_W(V)) dut (
      .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .ent_vector(ent_vector),
      .ent_mask(ent_mask), .ent_level(ent_level), .ent_polarity(ent_polarity),
      .reeval(reeval), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .remote_irr(remote_irr), .req_valid(req_valid), .req_ready(req_ready),
      .req_pin(req_pin), .req_vector(req_vector), .req_level(req_level)
   );

   always @(posedge clk) begin
      if (rst_n && req_valid && req_ready && n_log < 64) begin
         log_pin[n_log] = int'(req_pin);
         log_vec[n_log] = int'(req_vector);
         log_lvl[n_log] = int'(req_level);
         n_log = n_log + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drive_pin(input int p, input logic v);
      @(negedge clk);
      pin_raw[p] = v;
      settle(6);
   endtask

   task automatic send_eoi(input logic [V-1:0] vec);
      @(negedge clk);
      eoi_valid = 1'b1;
      eoi_vector = vec;
      @(negedge clk);
      eoi_valid = 1'b0;
      settle(6);
   endtask

   task automatic pulse_reeval(input int p);
      @(negedge clk);
      reeval[p] = 1'b1;
      @(negedge clk);
      reeval[p] = 1'b0;
      settle(6);
   endtask

   task automatic t_reset();
      chk(req_valid == 1'b0, "R12 req_valid", int'(req_valid), 0);
      chk(remote_irr == '0, "R12 remote_irr", int'(remote_irr), 0);
   endtask

   task automatic t_edge();
      int n0 = n_log;
      ent_mask[2] = 1'b0;
      drive_pin(2, 1'b1);
      chk(n_log == n0 + 1, "R3 one delivery", n_log - n0, 1);
      chk(log_pin[n0] == 2 && log_vec[n0] == 'h22 && log_lvl[n0] == 0, "R3 payload",
          log_vec[n0], 'h22);
      settle(6);
      chk(n_log == n0 + 1, "R3 held high", n_log - n0, 1);
      drive_pin(2, 1'b0);
      drive_pin(2, 1'b1);
      chk(n_log == n0 + 2, "R3 second rise", n_log - n0, 2);
      chk(remote_irr[2] == 1'b0, "R3 edge no rirr", int'(remote_irr[2]), 0);
      drive_pin(2, 1'b0);
   endtask

   task automatic t_polarity();
      int n0 = n_log;
      @(negedge clk);
      pin_raw[3] = 1'b1;
      ent_polarity[3] = 1'b1;
      ent_mask[3] = 1'b0;
      settle(6);
      chk(n_log == n0, "R1 inactive high", n_log - n0, 0);
      drive_pin(3, 1'b0);
      chk(n_log == n0 + 1 && log_vec[n0] == 'h23, "R1 active low fires", n_log - n0, 1);
      drive_pin(3, 1'b1);
      chk(n_log == n0 + 1, "R1 release silent", n_log - n0, 1);
   endtask

   task automatic t_level_eoi();
      int n0 = n_log;
      ent_level[4] = 1'b1;
      ent_mask[4] = 1'b0;
      drive_pin(4, 1'b1);
      chk(n_log == n0 + 1 && log_lvl[n0] == 1, "R4 level delivered", n_log - n0, 1);
      chk(remote_irr[4] == 1'b1, "R4 rirr set", int'(remote_irr[4]), 1);
      drive_pin(4, 1'b0);
      drive_pin(4, 1'b1);
      chk(n_log == n0 + 1, "R4 blocked by rirr", n_log - n0, 1);
      send_eoi(8'h24);
      chk(n_log == n0 + 2 && log_pin[n0+1] == 4, "R8 redelivery", n_log - n0, 2);
      chk(remote_irr[4] == 1'b0, "R8 redelivery leaves rirr clear", int'(remote_irr[4]), 0);
      drive_pin(4, 1'b0);
      drive_pin(4, 1'b1);
      chk(n_log == n0 + 3 && remote_irr[4], "R4 rise after eoi", n_log - n0, 3);
      drive_pin(4, 1'b0);
      send_eoi(8'h24);
      chk(n_log == n0 + 3, "R8 no redelivery when low", n_log - n0, 3);
      chk(remote_irr[4] == 1'b0, "R8 rirr cleared", int'(remote_irr[4]), 0);
   endtask

   task automatic t_shared_vector();
      int n0 = n_log;
      ent_vector[5*V +: V] = 8'h40;
      ent_vector[6*V +: V] = 8'h40;
      ent_level[5] = 1'b1; ent_level[6] = 1'b1;
      ent_mask[5] = 1'b0;  ent_mask[6] = 1'b0;
      drive_pin(5, 1'b1);
      drive_pin(6, 1'b1);
      drive_pin(5, 1'b0);
      drive_pin(6, 1'b0);
      chk(remote_irr[6:5] == 2'b11, "R6 both set", int'(remote_irr[6:5]), 3);
      send_eoi(8'h40);
      chk(remote_irr[6:5] == 2'b10, "R6 lowest only", int'(remote_irr[6:5]), 2);
      send_eoi(8'h99);
      chk(remote_irr[6:5] == 2'b10, "R7 unmatched ignored", int'(remote_irr[6:5]), 2);
      chk(n_log == n0 + 2, "R7 no delivery", n_log - n0, 2);
   endtask

   task automatic t_masked();
      int n0 = n_log;
      drive_pin(1, 1'b1);
      chk(n_log == n0, "R5 masked edge silent", n_log - n0, 0);
      ent_mask[1] = 1'b0;
      pulse_reeval(1);
      chk(n_log == n0, "R5 edge pending cleared", n_log - n0, 0);
      drive_pin(1, 1'b0);
      ent_level[7] = 1'b1;
      drive_pin(7, 1'b1);
      chk(n_log == n0 && remote_irr[7] == 1'b0, "R5 masked level silent", n_log - n0, 0);
      ent_mask[7] = 1'b0;
      pulse_reeval(7);
      chk(n_log == n0 + 1 && log_pin[n0] == 7, "R9 reeval delivers", n_log - n0, 1);
      chk(remote_irr[7] == 1'b1, "R9 rirr after reeval", int'(remote_irr[7]), 1);
      ent_level[0] = 1'b1;
      drive_pin(0, 1'b1);
      drive_pin(0, 1'b0);
      ent_mask[0] = 1'b0;
      pulse_reeval(0);
      chk(n_log == n0 + 1, "R2 low clears pending", n_log - n0, 1);
   endtask

   task automatic t_priority();
      int n0 = n_log;
      @(negedge clk);
      req_ready = 1'b0;
      pin_raw[1] = 1'b1;
      pin_raw[2] = 1'b1;
      settle(5);
      chk(req_valid && req_pin == 1, "R10 lowest first", int'(req_pin), 1);
      settle(3);
      chk(req_valid && req_pin == 1 && req_vector == 8'h21, "R11 held", int'(req_pin), 1);
      @(negedge clk);
      req_ready = 1'b1;
      settle(6);
      chk(n_log == n0 + 2, "R11 none lost", n_log - n0, 2);
      chk(log_pin[n0] == 1 && log_pin[n0+1] == 2, "R10 order", log_pin[n0+1], 2);
   endtask

   initial begin
      for (int i = 0; i < N; i++) ent_vector[i*V +: V] = V'(8'h20 + i);
      settle(3);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      settle(2);
      t_edge();
      t_polarity();
      t_level_eoi();
      t_shared_vector();
      t_masked();
      t_priority();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule